// File: doc/BRIEF.md
# Wormhole Router Input Port with Credit Flow Control

This block is one input port of a wormhole-switched packet router. An upstream router pushes flits into it. Each flit is a 32-bit word with a start-of-packet marker and an end-of-packet marker. The port stores the flits in a small FIFO and keeps a credit level high toward the sender for as long as the FIFO has room. While that credit is high, the sender may issue one flit per clock, qualified by its request line.

On the outgoing side, the flit at the front of the FIFO is offered to the routing unit through a head-flit tap, so that the destination can be decoded. The port then releases the packet toward the crossbar, one flit per cycle. It does so only while the switch allocator's grant and the downstream credit are both high. A new packet can flow in while the previous one is still draining. Routing, arbitration and the crossbar are outside this block.

Top module: `wh_input_port`

## Requirements
- R1: Flit format. Each flit is a 32-bit data word, a start marker (bit 33 of the stored flit) and an end marker (bit 32). Flits leave on `dn_data_o`, `dn_bop_o` and `dn_eop_o` in arrival order, with their markers unchanged.
- R2: `up_credit_o` is high exactly when the FIFO holds fewer than DEPTH flits.
- R3: While `up_credit_o` is high, a flit offered with `up_req_i` is accepted in that cycle. DEPTH flits sent back to back with no reads fill the FIFO.
- R4: A packet opens with a flit that has both `up_req_i` and `up_bop_i` high. It closes with the accepted flit that has `up_eop_i` high. A flit offered while no packet is open and without `up_bop_i` is discarded and never appears downstream.
- R5: Flits of a new packet are accepted while an earlier packet is still waiting in the FIFO or leaving it.
- R6: `dn_req_o` is high only when the FIFO is non-empty and `grant_i` and `dn_credit_i` are both high. One flit leaves on every cycle that `dn_req_o` is high.
- R7: A flit that would be accepted but arrives while the FIFO is full is dropped. `ovf_err_o` is high in that same cycle, and the FIFO contents are unchanged.
- R8: `head_valid_o` is high when the front flit carries the start marker and no packet is in transmission. `head_data_o` then shows that flit's data.
- R9: During and right after reset, the FIFO is empty, `up_credit_o` is high, and `dn_req_o` and `head_valid_o` are low.
- R10: Once the first flit of a packet has left, the port sends only that packet's flits, and `head_valid_o` stays low until its end-marked flit has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_data_i | input | 32 | Incoming flit data |
| up_bop_i | input | 1 | Incoming start-of-packet marker |
| up_eop_i | input | 1 | Incoming end-of-packet marker |
| up_req_i | input | 1 | Incoming flit valid |
| up_credit_o | output | 1 | FIFO not full, sender may send |
| ovf_err_o | output | 1 | Flit dropped on a full FIFO |
| dn_credit_i | input | 1 | Downstream can take a flit |
| grant_i | input | 1 | Output granted by the switch allocator |
| dn_data_o | output | 32 | Outgoing flit data |
| dn_bop_o | output | 1 | Outgoing start-of-packet marker |
| dn_eop_o | output | 1 | Outgoing end-of-packet marker |
| dn_req_o | output | 1 | Outgoing flit valid, flit leaves this cycle |
| head_valid_o | output | 1 | Head flit present for routing |
| head_data_o | output | 32 | Data of the head flit |

## Verification
The bench builds the port with DEPTH = 4, so the FIFO fills in four cycles. This keeps the full-FIFO credit drop, the overflow drop and simultaneous read and write at the full boundary within easy reach. Random packets of one to five flits are longer than the FIFO at times. This produces packets that span the full state, packets that enter while an earlier packet drains, and single-flit packets whose start and end markers coincide. Random grant and downstream credit stall packets in mid-flight.

// File: rtl/wh_port_pkg.sv
package wh_port_pkg;
  localparam int unsigned FLIT_DATA_W = 32;

  typedef struct packed {
    logic                   bop;
    logic                   eop;
    logic [FLIT_DATA_W-1:0] data;
  } flit_t;
endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo
  import wh_port_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  flit_t wdata_i,
  input  logic  pop_i,
  output flit_t rdata_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  flit_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/wh_rx_ctrl.sv
module wh_rx_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic bop_i,
  input  logic eop_i,
  input  logic full_i,
  output logic push_o,
  output logic err_o,
  output logic credit_o
);
  logic pkt_open;
  logic framed;

  // flit belongs to a packet: opens one or continues one
  assign framed   = req_i && (bop_i || pkt_open);
  assign push_o   = framed && !full_i;
  assign err_o    = framed && full_i;
  assign credit_o = !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pkt_open <= 1'b0;
    else if (push_o) pkt_open <= !eop_i;
  end
endmodule

// File: rtl/wh_tx_ctrl.sv
module wh_tx_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic front_bop_i,
  input  logic front_eop_i,
  input  logic grant_i,
  input  logic dn_credit_i,
  output logic pop_o,
  output logic head_valid_o
);
  logic sending;

  assign head_valid_o = !empty_i && front_bop_i && !sending;
  assign pop_o        = !empty_i && grant_i && dn_credit_i && (sending || front_bop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sending <= 1'b0;
    else if (pop_o) sending <= !front_eop_i;
  end
endmodule

// File: rtl/wh_input_port.sv
module wh_input_port
  import wh_port_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [FLIT_DATA_W-1:0] up_data_i,
  input  logic                   up_bop_i,
  input  logic                   up_eop_i,
  input  logic                   up_req_i,
  output logic                   up_credit_o,
  output logic                   ovf_err_o,
  input  logic                   dn_credit_i,
  input  logic                   grant_i,
  output logic [FLIT_DATA_W-1:0] dn_data_o,
  output logic                   dn_bop_o,
  output logic                   dn_eop_o,
  output logic                   dn_req_o,
  output logic                   head_valid_o,
  output logic [FLIT_DATA_W-1:0] head_data_o
);
  flit_t wflit, front;
  logic  push, pop, empty, full;

  assign wflit = '{bop: up_bop_i, eop: up_eop_i, data: up_data_i};

  wh_rx_ctrl u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (up_req_i),
    .bop_i   (up_bop_i),
    .eop_i   (up_eop_i),
    .full_i  (full),
    .push_o  (push),
    .err_o   (ovf_err_o),
    .credit_o(up_credit_o)
  );

  wh_flit_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(wflit),
    .pop_i  (pop),
    .rdata_o(front),
    .empty_o(empty),
    .full_o (full)
  );

  wh_tx_ctrl u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .empty_i     (empty),
    .front_bop_i (front.bop),
    .front_eop_i (front.eop),
    .grant_i     (grant_i),
    .dn_credit_i (dn_credit_i),
    .pop_o       (pop),
    .head_valid_o(head_valid_o)
  );

  assign dn_req_o    = pop;
  assign dn_data_o   = front.data;
  assign dn_bop_o    = front.bop;
  assign dn_eop_o    = front.eop;
  assign head_data_o = front.data;
endmodule

// File: rtl/wh_input_port_chk.sv
module wh_input_port_chk
  import wh_port_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   up_req_i,
  input logic                   up_credit_o,
  input logic                   ovf_err_o,
  input logic                   dn_credit_i,
  input logic                   grant_i,
  input logic [FLIT_DATA_W-1:0] dn_data_o,
  input logic                   dn_bop_o,
  input logic                   dn_eop_o,
  input logic                   dn_req_o,
  input logic                   head_valid_o,
  input logic [FLIT_DATA_W-1:0] head_data_o
);
  assert_reset_R9: assert property (@(posedge clk_i)
    !rst_ni |-> up_credit_o && !dn_req_o && !head_valid_o);

  assert_credit_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_credit_o) |-> $past(dn_req_o));

  assert_credit_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_credit_o) |-> $past(up_req_i));

  assert_gated_send_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> grant_i && dn_credit_i);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |-> up_req_i && !up_credit_o);

  assert_head_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_o && dn_req_o |-> dn_bop_o && dn_data_o == head_data_o);

  assert_in_packet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_eop_o |=> !head_valid_o);
endmodule

bind wh_input_port wh_input_port_chk u_chk (.*);

// File: tb/wh_input_port_test.sv
module wh_input_port_test;
  localparam int unsigned DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] up_data = '0;
  logic        up_bop = 1'b0, up_eop = 1'b0, up_req = 1'b0;
  logic        dn_credit = 1'b0, grant = 1'b0;
  logic        up_credit, ovf_err, dn_bop, dn_eop, dn_req, head_valid;
  logic [31:0] dn_data, head_data;

  int unsigned n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  logic [33:0] q[$];   // {bop, eop, data}
  bit          m_open = 1'b0, m_send = 1'b0;

  always #5 clk = ~clk;

  wh_input_port #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .up_data_i(up_data), .up_bop_i(up_bop), .up_eop_i(up_eop), .up_req_i(up_req),
    .up_credit_o(up_credit), .ovf_err_o(ovf_err),
    .dn_credit_i(dn_credit), .grant_i(grant),
    .dn_data_o(dn_data), .dn_bop_o(dn_bop), .dn_eop_o(dn_eop), .dn_req_o(dn_req),
    .head_valid_o(head_valid), .head_data_o(head_data)
  );

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_credit();
    return q.size() < DEPTH;
  endfunction

  function automatic bit exp_send(input bit g, input bit c);
    return (q.size() > 0) && g && c && (m_send || q[0][33]);
  endfunction

  task automatic cyc(input bit req, input bit bop, input bit eop, input logic [31:0] d,
                     input bit g, input bit c);
    bit acc, err, snd, hv;
    @(negedge clk);
    up_req = req; up_bop = bop; up_eop = eop; up_data = d; grant = g; dn_credit = c;
    #4;
    check("R2 credit", 34'(up_credit), 34'(exp_credit()));
    acc = req && exp_credit() && (bop || m_open);
    err = req && !exp_credit() && (bop || m_open);
    check("R7 overflow flag", 34'(ovf_err), 34'(err));
    snd = exp_send(g, c);
    check("R6 send", 34'(dn_req), 34'(snd));
    if (snd && dn_req) check("R1 flit out", {dn_bop, dn_eop, dn_data}, q[0]);
    hv = (q.size() > 0) && q[0][33] && !m_send;
    check("R8 R10 head valid", 34'(head_valid), 34'(hv));
    if (hv) check("R8 head data", 34'(head_data), 34'(q[0][31:0]));
    if (snd) begin
      m_send = !q[0][32];
      void'(q.pop_front());
    end
    if (acc) begin
      q.push_back({bop, eop, d});
      m_open = !eop;
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned rem;
    bit          s_open;
    void'($urandom(32'h5eed_1234));
    #1 rst_ni = 1'b0;
    #2;
    check("R9 reset credit", 34'(up_credit), 34'd1);
    check("R9 reset send", 34'(dn_req), 34'd0);
    check("R9 reset head", 34'(head_valid), 34'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R3: fill to DEPTH without reads, then R7 overflow attempt
    cyc(1, 1, 0, 32'hA000_0000, 0, 1);
    for (int i = 1; i < DEPTH; i++) cyc(1, 0, 0, 32'hA000_0000 + i, 0, 1);
    cyc(1, 0, 1, 32'hDEAD_0001, 0, 1);
    cyc(1, 0, 1, 32'hDEAD_0002, 1, 1);
    cyc(1, 0, 1, 32'hA000_00FF, 1, 1);
    // R5: next packet enters while the first drains
    cyc(1, 1, 1, 32'hB000_0001, 1, 1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 32'h0, 1, 1);
    // R4: stray body flit outside a packet is discarded
    cyc(1, 0, 0, 32'hBAD0_0000, 1, 1);
    cyc(1, 0, 1, 32'hBAD0_0001, 1, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 32'h0, 1, 1);
    // R6: downstream credit low holds the flit
    cyc(1, 1, 0, 32'hC000_0000, 1, 0);
    cyc(1, 0, 1, 32'hC000_0001, 1, 0);
    cyc(0, 0, 0, 32'h0, 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 32'h0, 1, 1);

    // random traffic: R1 R3 R5 R6 R7 R10
    rem = 0; s_open = 0;
    for (int i = 0; i < 4000; i++) begin
      bit req, bop, eop, g, c, acc_now;
      logic [31:0] d;
      d = $urandom();
      g = ($urandom() % 4) != 0;
      c = ($urandom() % 5) != 0;
      req = ($urandom() % 3) != 0;
      if (!exp_credit() && ($urandom() % 4) != 0) req = 0;
      if (!s_open) begin
        if (($urandom() % 20) == 0) begin bop = 0; eop = 0; end
        else begin rem = 1 + $urandom() % 5; bop = 1; eop = (rem == 1); end
      end else begin
        bop = 0; eop = (rem == 1);
      end
      acc_now = req && exp_credit() && (bop || m_open);
      cyc(req, bop, eop, d, g, c);
      if (acc_now) begin
        if (eop) s_open = 0; else begin s_open = 1; rem--; end
      end
    end
    for (int i = 0; i < 2 * DEPTH + 4; i++) cyc(0, 0, 0, 32'h0, 1, 1);
    check("R1 drained", 34'(q.size()), 34'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule